// File: doc/BRIEF.md
# Code Memory Programming and Protected Verify Unit

This block is the programming and read-out path of an on-chip one-time-programmable code store. An external programmer picks an operation on a 3-bit mode input, presents a 14-bit address and a data byte, and pulses an active-low program strobe while a flag says the programming voltage is present. A write commits only after the required number of strobe pulses for that target, and only when the inputs have been stable long enough before each strobe falls. Programming can only clear bits.

Read-out of code is scrambled. Each verified byte is the stored code byte XNORed with one of 64 encryption bytes, picked by the low six address bits. Three lock bits, which cannot be read back, set a cumulative protection level. The level drives the enables that the CPU uses and gates further programming and verify. Fixed signature bytes can be read at three addresses.

The code store is a register array indexed by the low `CODE_AW` address bits. Reset models an erased part, so all code, encryption and lock bits read as 1.

Top module: `otp_prog_verify`

## Requirements
- R1: After reset all stored bits are 1, so every enable output is 1 except `ea_latch_o`, which is 0, and a verify of any address returns 0xFF.
- R2: With mode 1 (program code), the byte is written on the 5th qualified strobe pulse for an unchanged target. After 4 pulses it is unchanged, and further pulses after the commit write nothing new.
- R3: With mode 3 (program encryption byte, selected by address bits 5:0) and modes 4, 5 and 6 (program lock bit 1, 2 and 3), the write commits on the 25th qualified pulse. After 24 pulses it has no effect.
- R4: Programming can only clear bits: a committed code or encryption write stores the old byte AND the data. Lock bits never return to 1 except by reset.
- R5: With mode 2 (verify), `vfy_data_o` equals code byte XNOR the encryption byte chosen by address bits 5:0. An erased encryption byte returns the code unchanged.
- R6: Strobe pulses while `vpp_i` is 0 are not counted.
- R7: A strobe fall is counted only after mode, address and data have stayed unchanged for `SETUP_CLKS` (48) clocks. Any change of them restarts the pulse count for the new target.
- R8: With lock bit 1 programmed, `movc_int_en_o` is 0, `ea_latch_o` is 1 and `prog_en_o` is 0. Code and encryption programming is then ignored, but lock bits can still be programmed.
- R9: With lock bits 1 and 2 programmed, `verify_en_o` is 0 and verify reads return 0xFF.
- R10: With all three lock bits programmed, `ext_exec_en_o` is 0, in addition to everything in R9.
- R11: Lock bits 2 or 3 programmed without lock bit 1 give no protection. With lock bit 1 programmed and lock bit 2 not, the level is that of R8, whatever lock bit 3 holds.
- R12: With mode 7 (signature), the address 0x0030 returns 0x89, 0x0031 returns 0x58, 0x0060 returns `DEV_CODE` (default 0xFB), and any other address returns 0xFF. Modes 0 and 1 and 3 to 6 read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (erased state) |
| mode_i | input | 3 | Operation select, codes as in the requirements |
| addr_i | input | 14 | Target address |
| data_i | input | 8 | Byte to program |
| prog_n_i | input | 1 | Active-low program strobe |
| vpp_i | input | 1 | Programming voltage present |
| vfy_data_o | output | 8 | Verify or signature read data |
| movc_int_en_o | output | 1 | Table reads from external code may read internal code |
| ea_latch_o | output | 1 | External-access strap is latched at reset |
| prog_en_o | output | 1 | Code and encryption programming allowed |
| verify_en_o | output | 1 | Code verify allowed |
| ext_exec_en_o | output | 1 | Execution from external code allowed |

## Verification
The bench goes after the pulse-count boundaries: 4 against 5 code pulses, and 24 against 25 encryption and lock pulses. A design with an off-by-one count would commit one pulse early or one pulse late. It replays strobes that arrive too soon after a target change, and strobes after a brief data glitch. A design that skipped the setup window, or failed to restart the count, would commit there. It programs lock bits in unlisted orders (bit 3 alone, bit 2 alone, then bit 1). A decoder that read the bits independently would protect too much or too little. It also checks that locked programming leaves the code and encryption bytes unchanged, and that the XNOR uses only six address bits, where a wider index would pick an erased encryption byte.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_PCODE  = 3'd1,
    M_VCODE  = 3'd2,
    M_PCRYPT = 3'd3,
    M_PLB1   = 3'd4,
    M_PLB2   = 3'd5,
    M_PLB3   = 3'd6,
    M_RSIG   = 3'd7
  } mode_e;

  localparam int unsigned SIG_A0 = 'h30;
  localparam int unsigned SIG_A1 = 'h31;
  localparam int unsigned SIG_A2 = 'h60;
  localparam logic [7:0]  SIG_V0 = 8'h89;
  localparam logic [7:0]  SIG_V1 = 8'h58;

  function automatic logic [7:0] sig_byte(input logic [13:0] a, input logic [7:0] dev);
    if (a == 14'(SIG_A0))      return SIG_V0;
    else if (a == 14'(SIG_A1)) return SIG_V1;
    else if (a == 14'(SIG_A2)) return dev;
    else                       return 8'hFF;
  endfunction

  function automatic logic is_lock_mode(input mode_e m);
    return (m == M_PLB1) || (m == M_PLB2) || (m == M_PLB3);
  endfunction
endpackage

// File: rtl/otp_setup_guard.sv
module otp_setup_guard #(
  parameter int TGT_W      = 25,
  parameter int SETUP_CLKS = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TGT_W-1:0] tgt_i,
  input  logic             prog_n_i,
  input  logic             vpp_i,
  output logic             strobe_o,
  output logic             tgt_chg_o
);
  localparam int SC_W = $clog2(SETUP_CLKS + 1);

  logic [TGT_W-1:0] snap_q;
  logic [SC_W-1:0]  stab_q;
  logic             prog_q;
  logic             ready;

  assign tgt_chg_o = (snap_q != tgt_i);
  assign ready     = (stab_q == SC_W'(SETUP_CLKS));
  assign strobe_o  = prog_q & ~prog_n_i & vpp_i & ready & ~tgt_chg_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      stab_q <= '0;
      prog_q <= 1'b1;
    end else begin
      prog_q <= prog_n_i;
      snap_q <= tgt_i;
      if (tgt_chg_o)  stab_q <= '0;
      else if (!ready) stab_q <= stab_q + 1'b1;
    end
  end

  // a counted strobe never sees a target that moved in the last cycle
  p_setup_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $stable(tgt_i));
endmodule

// File: rtl/otp_pulse_ctr.sv
module otp_pulse_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             pulse_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             commit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign commit_o = pulse_i & ~clr_i & ~done_q & (cnt_q == need_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (commit_o) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else if (pulse_i && !done_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  p_commit_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
endmodule

// File: rtl/otp_lock_decode.sv
module otp_lock_decode (
  input  logic [2:0] lb_i,  // 1 = unprogrammed
  output logic       movc_int_en_o,
  output logic       ea_latch_o,
  output logic       prog_en_o,
  output logic       verify_en_o,
  output logic       ext_exec_en_o
);
  logic [2:0] lvl;  // 1..4

  always_comb begin
    if (lb_i[0])      lvl = 3'd1;
    else if (lb_i[1]) lvl = 3'd2;
    else if (lb_i[2]) lvl = 3'd3;
    else              lvl = 3'd4;
  end

  assign movc_int_en_o = (lvl < 3'd2);
  assign ea_latch_o    = (lvl >= 3'd2);
  assign prog_en_o     = (lvl < 3'd2);
  assign verify_en_o   = (lvl < 3'd3);
  assign ext_exec_en_o = (lvl < 3'd4);
endmodule

// File: rtl/otp_prog_verify.sv
module otp_prog_verify
  import otp_pkg::*;
#(
  parameter int         ADDR_W      = 14,
  parameter int         DATA_W      = 8,
  parameter int         CODE_AW     = 8,
  parameter int         CRYPT_AW    = 6,
  parameter int         SETUP_CLKS  = 48,
  parameter int         CODE_PULSES = 5,
  parameter int         AUX_PULSES  = 25,
  parameter logic [7:0] DEV_CODE    = 8'hFB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              prog_n_i,
  input  logic              vpp_i,
  output logic [DATA_W-1:0] vfy_data_o,
  output logic              movc_int_en_o,
  output logic              ea_latch_o,
  output logic              prog_en_o,
  output logic              verify_en_o,
  output logic              ext_exec_en_o
);
  localparam int CODE_N = 1 << CODE_AW;
  localparam int CRYPT_N = 1 << CRYPT_AW;
  localparam int TGT_W = 3 + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(AUX_PULSES + 1);

  mode_e mode;
  assign mode = mode_e'(mode_i);

  logic [DATA_W-1:0] code_q  [CODE_N];
  logic [DATA_W-1:0] crypt_q [CRYPT_N];
  logic [2:0]        lb_q;

  logic [CODE_AW-1:0]  cidx;
  logic [CRYPT_AW-1:0] eidx;
  assign cidx = addr_i[CODE_AW-1:0];
  assign eidx = addr_i[CRYPT_AW-1:0];

  logic strobe, tgt_chg, allow, commit;
  logic [CNT_W-1:0] need;

  otp_setup_guard #(.TGT_W(TGT_W), .SETUP_CLKS(SETUP_CLKS)) u_guard (
    .clk_i, .rst_ni,
    .tgt_i    ({mode_i, addr_i, data_i}),
    .prog_n_i, .vpp_i,
    .strobe_o (strobe),
    .tgt_chg_o(tgt_chg)
  );

  always_comb begin
    unique case (mode)
      M_PCODE, M_PCRYPT:    allow = prog_en_o;
      M_PLB1, M_PLB2, M_PLB3: allow = 1'b1;
      default:              allow = 1'b0;
    endcase
  end

  assign need = (mode == M_PCODE) ? CNT_W'(CODE_PULSES) : CNT_W'(AUX_PULSES);

  otp_pulse_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i   (tgt_chg),
    .pulse_i (strobe & allow),
    .need_i  (need),
    .commit_o(commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CODE_N; i++) code_q[i] <= '1;
    end else if (commit && mode == M_PCODE) begin
      code_q[cidx] <= code_q[cidx] & data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CRYPT_N; i++) crypt_q[i] <= '1;
    end else if (commit && mode == M_PCRYPT) begin
      crypt_q[eidx] <= crypt_q[eidx] & data_i;
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_lb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    lb_q[g] <= 1'b1;
      else if (commit && mode_i == 3'(int'(M_PLB1) + g)) lb_q[g] <= 1'b0;
    end
  end

  otp_lock_decode u_lock (
    .lb_i          (lb_q),
    .movc_int_en_o,
    .ea_latch_o,
    .prog_en_o,
    .verify_en_o,
    .ext_exec_en_o
  );

  always_comb begin
    unique case (mode)
      M_VCODE: vfy_data_o = verify_en_o ? (code_q[cidx] ~^ crypt_q[eidx]) : '1;
      M_RSIG:  vfy_data_o = sig_byte(14'(addr_i), DEV_CODE);
      default: vfy_data_o = '1;
    endcase
  end

  p_lock_clear_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_q & ~$past(lb_q)) == 3'b000);
  p_commit_vpp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> vpp_i);
  p_lock_cumulative_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !verify_en_o |-> (!prog_en_o && ea_latch_o));
  p_ext_cumulative_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_exec_en_o |-> !verify_en_o);
endmodule

// File: tb/otp_prog_verify_tb_top.sv
module otp_prog_verify_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [13:0] addr = '0;
  logic [7:0]  data = '0;
  logic prog_n = 1'b1;
  logic vpp = 1'b0;
  logic [7:0] vfy;
  logic movc_en, ea_latch, prog_en, ver_en, ext_en;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_prog_verify dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .addr_i(addr), .data_i(data),
    .prog_n_i(prog_n), .vpp_i(vpp), .vfy_data_o(vfy),
    .movc_int_en_o(movc_en), .ea_latch_o(ea_latch), .prog_en_o(prog_en),
    .verify_en_o(ver_en), .ext_exec_en_o(ext_en)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [13:0] addr;
    logic [7:0]  data;
    logic [4:0]  pulses;
    logic        vpp;
    logic [13:0] vaddr;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 14'h005, 8'hA5, 5'd5,  1'b1, 14'h005, 8'hA5},  // R2
    '{3'd1, 14'h006, 8'h3C, 5'd4,  1'b1, 14'h006, 8'hFF},  // R2
    '{3'd1, 14'h005, 8'h0F, 5'd5,  1'b1, 14'h005, 8'h05},  // R4
    '{3'd3, 14'h005, 8'hF0, 5'd24, 1'b1, 14'h005, 8'h05},  // R3
    '{3'd3, 14'h005, 8'hF0, 5'd25, 1'b1, 14'h005, 8'h0A},  // R5
    '{3'd1, 14'h045, 8'hFF, 5'd5,  1'b1, 14'h045, 8'hF0},  // R5
    '{3'd1, 14'h007, 8'h81, 5'd5,  1'b1, 14'h007, 8'h81},  // R2
    '{3'd1, 14'h008, 8'h00, 5'd5,  1'b0, 14'h008, 8'hFF}   // R6
  };

  function automatic string row_tag(input int i);
    case (i)
      2:       return "R4";
      3:       return "R3";
      4, 5:    return "R5";
      7:       return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic chk8(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic chk_en(input logic [4:0] exp, input string tag);
    n_tests++;
    if ({movc_en, ea_latch, prog_en, ver_en, ext_en} !== exp) begin
      n_fail++;
      $display("FAIL %s: enables got %05b expected %05b", tag,
               {movc_en, ea_latch, prog_en, ver_en, ext_en}, exp);
    end
  endtask

  task automatic set_tgt(input logic [2:0] m, input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    mode = m; addr = a; data = d;
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) prog_n = 1'b0;
      repeat (2) @(negedge clk);
      prog_n = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic prog_op(input logic [2:0] m, input logic [13:0] a, input logic [7:0] d,
                         input int n, input logic v);
    vpp = v;
    set_tgt(m, a, d);
    repeat (SETTLE) @(negedge clk);
    pulses(n);
    vpp = 1'b1;
  endtask

  task automatic rd(input logic [2:0] m, input logic [13:0] a, output logic [7:0] q);
    set_tgt(m, a, 8'h00);
    @(negedge clk);
    q = vfy;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] q;
    do_reset();
    // R1: erased state
    chk_en(5'b10111, "R1 reset enables");
    rd(3'd2, 14'h005, q); chk8(q, 8'hFF, "R1 erased verify");

    for (int i = 0; i < NV; i++) begin
      prog_op(VECS[i].mode, VECS[i].addr, VECS[i].data, int'(VECS[i].pulses), VECS[i].vpp);
      rd(3'd2, VECS[i].vaddr, q);
      chk8(q, VECS[i].exp, $sformatf("%s row %0d", row_tag(i), i));
    end

    // R7: strobes inside the setup window are ignored
    vpp = 1'b1;
    set_tgt(3'd1, 14'h009, 8'h00);
    repeat (10) @(negedge clk);
    pulses(5);
    rd(3'd2, 14'h009, q); chk8(q, 8'hFF, "R7 early strobes");

    // R7: a data glitch restarts the count (3 + 2 pulses must not commit)
    prog_op(3'd1, 14'h00A, 8'h55, 3, 1'b1);
    set_tgt(3'd1, 14'h00A, 8'h56);
    set_tgt(3'd1, 14'h00A, 8'h55);
    repeat (SETTLE) @(negedge clk);
    pulses(2);
    rd(3'd2, 14'h00A, q); chk8(q, 8'hFF, "R7 count restart");

    // R12: signature
    rd(3'd7, 14'h030, q); chk8(q, 8'h89, "R12 sig 0x30");
    rd(3'd7, 14'h031, q); chk8(q, 8'h58, "R12 sig 0x31");
    rd(3'd7, 14'h060, q); chk8(q, 8'hFB, "R12 sig 0x60");
    rd(3'd7, 14'h061, q); chk8(q, 8'hFF, "R12 sig other");
    rd(3'd0, 14'h030, q); chk8(q, 8'hFF, "R12 idle mode read");

    // R11: lock bit 3 alone gives no protection
    prog_op(3'd6, 14'h000, 8'h00, 25, 1'b1);
    chk_en(5'b10111, "R11 lb3 only enables");
    rd(3'd2, 14'h005, q); chk8(q, 8'h0A, "R11 lb3 only verify");

    // R3 + R8: lock bit 1 at 24 then 25 pulses
    prog_op(3'd4, 14'h000, 8'h00, 24, 1'b1);
    chk_en(5'b10111, "R3 lb1 after 24 pulses");
    pulses(1);
    chk_en(5'b01011, "R8 R11 lb1+lb3 level");
    prog_op(3'd1, 14'h00B, 8'h00, 5, 1'b1);
    rd(3'd2, 14'h00B, q); chk8(q, 8'hFF, "R8 code prog blocked");
    prog_op(3'd3, 14'h005, 8'h00, 25, 1'b1);
    rd(3'd2, 14'h005, q); chk8(q, 8'h0A, "R8 crypt prog blocked");

    // R10: all three lock bits
    prog_op(3'd5, 14'h000, 8'h00, 25, 1'b1);
    chk_en(5'b01000, "R10 level 4 enables");
    rd(3'd2, 14'h005, q); chk8(q, 8'hFF, "R10 verify blocked");

    // second part: fresh erased state
    do_reset();
    chk_en(5'b10111, "R1 enables after second reset");
    rd(3'd2, 14'h005, q); chk8(q, 8'hFF, "R1 code erased again");
    prog_op(3'd1, 14'h001, 8'h12, 5, 1'b1);
    prog_op(3'd5, 14'h000, 8'h00, 25, 1'b1);
    chk_en(5'b10111, "R11 lb2 only enables");
    rd(3'd2, 14'h001, q); chk8(q, 8'h12, "R11 lb2 only verify");
    prog_op(3'd4, 14'h000, 8'h00, 25, 1'b1);
    chk_en(5'b01001, "R9 level 3 enables");
    rd(3'd2, 14'h001, q); chk8(q, 8'hFF, "R9 verify blocked");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule